// File: doc/BRIEF.md
# Acknowledge-Gated Staging Buffer Controller

This controller takes a stream of user data words and writes them into an external on-chip staging memory. The memory is split into fixed-size slots. By default there are four slots of 8 KB each, 32 KB in total. Words fill one slot at a time, in address order. When the last word of a slot has been accepted, the controller raises a one-cycle request that tells the descriptor logic this slot can now be moved to the host.

A slot that has been handed over stays locked until the DMA engine acknowledges it. An acknowledge means the slot's contents have reached host memory. Slots are handled as a ring, with one pointer for the slot being written and one for the oldest slot still waiting for an acknowledge. Each acknowledge releases the oldest waiting slot. When every slot is waiting, the input stalls through its ready signal until an acknowledge arrives.

An acknowledge that arrives while no slot is waiting is treated as a protocol error. It is recorded in a sticky flag and has no other effect.

Top module: `stage_buf_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `in_ready_o` is 1 and `mem_we_o`, `slot_req_o` and `ack_err_o` are 0.
- R2: Every accepted beat (`in_valid_i` and `in_ready_o` both high at a clock edge) produces exactly one memory write on the next cycle. The write has `mem_wdata_o` equal to the beat's data and `mem_addr_o` = {slot index, word index}, with the word index in the low log2(SLOT_WORDS) bits.
- R3: `slot_req_o` is high for exactly one cycle per filled slot. That cycle is the one in which the slot's final word (word index SLOT_WORDS-1) is written, and `slot_req_o` is low on every other write.
- R4: Slots fill in ring order 0, 1, 2, 3, 0, … . `slot_req_idx_o` carries the index of the slot being handed over, and the word index restarts at 0 in each new slot.
- R5: When all NUM_SLOTS slots are waiting for an acknowledge, `in_ready_o` is 0 and no memory write occurs however long `in_valid_i` is held.
- R6: A `dma_ack_i` pulse while at least one slot is waiting releases exactly one slot, the oldest. `in_ready_o` is high in the cycle after an acknowledge that releases a slot from the all-waiting state.
- R7: A `dma_ack_i` pulse while no slot is waiting sets `ack_err_o`, which stays 1 until reset. Such an acknowledge does not change the ring pointers, so later writes continue at the expected slot and word.
- R8: In cycles with `in_valid_i` low, no write occurs and the fill position does not advance.
- R9: With default parameters, a slot holds 1024 words of 64 bits (8 KB), there are 4 slots, and `mem_addr_o` is 12 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | User data word valid |
| in_data_i | input | DATA_W | User data word |
| in_ready_o | output | 1 | Controller can accept a word |
| mem_we_o | output | 1 | Staging memory write enable |
| mem_addr_o | output | ADDR_W | Staging memory word address {slot, word} |
| mem_wdata_o | output | DATA_W | Staging memory write data |
| slot_req_o | output | 1 | One-cycle pulse: slot full, request transfer |
| slot_req_idx_o | output | SLOT_IDX_W | Index of the slot being requested |
| dma_ack_i | input | 1 | DMA acknowledge: oldest waiting slot is in host memory |
| ack_err_o | output | 1 | Sticky flag: acknowledge with no waiting slot |

## Verification
Some properties are checked on every cycle. Every accepted beat must produce a write one cycle later carrying that beat's data. Idle cycles must produce no writes. Transfer requests must coincide exactly with writes to a slot's last word and must come in ring order. The error flag, once set, must never clear.

Other behaviour depends on how many slots are waiting, so only the directed scenarios can show it. These scenarios cover the stall when all four slots are waiting, the single-slot release by one acknowledge, and the wrap back to slot 0. They also cover the exact addresses across gaps in the input, and the fact that a spurious acknowledge leaves the ring position untouched.

// File: rtl/stage_buf_pkg.sv
`timescale 1ns/1ps
package stage_buf_pkg;
  localparam int unsigned DEF_DATA_W     = 64;
  localparam int unsigned DEF_SLOT_BYTES = 8192;
  localparam int unsigned DEF_NUM_SLOTS  = 4;

  function automatic int unsigned slot_words(input int unsigned data_w, input int unsigned slot_bytes);
    return slot_bytes / (data_w / 8);
  endfunction
endpackage

// File: rtl/stage_ring_trk.sv
`timescale 1ns/1ps
module stage_ring_trk #(
  parameter int unsigned NUM_SLOTS  = 4,
  parameter int unsigned SLOT_IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  fill_done_i,
  input  logic                  ack_i,
  output logic                  space_o,
  output logic [SLOT_IDX_W-1:0] wr_idx_o,
  output logic                  err_o
);
  localparam int unsigned PTR_W = SLOT_IDX_W + 1;

  logic [PTR_W-1:0] wr_q, rel_q;
  logic             err_q;
  logic             empty, full, ack_ok, ack_bad;

  // extra wrap bit separates full from empty
  assign empty   = (wr_q == rel_q);
  assign full    = (wr_q[SLOT_IDX_W] != rel_q[SLOT_IDX_W]) &&
                   (wr_q[SLOT_IDX_W-1:0] == rel_q[SLOT_IDX_W-1:0]);
  assign ack_ok  = ack_i && !empty;
  assign ack_bad = ack_i && empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rel_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (fill_done_i) wr_q  <= wr_q + {{(PTR_W-1){1'b0}}, 1'b1};
      if (ack_ok)      rel_q <= rel_q + {{(PTR_W-1){1'b0}}, 1'b1};
      if (ack_bad)     err_q <= 1'b1;
    end
  end

  assign space_o  = !full;
  assign wr_idx_o = wr_q[SLOT_IDX_W-1:0];
  assign err_o    = err_q;
endmodule

// File: rtl/stage_fill_ctr.sv
`timescale 1ns/1ps
module stage_fill_ctr #(
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned SLOT_WORDS = 1024,
  parameter int unsigned SLOT_IDX_W = 2,
  parameter int unsigned WORD_W     = $clog2(SLOT_WORDS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         beat_i,
  input  logic [DATA_W-1:0]            data_i,
  input  logic [SLOT_IDX_W-1:0]        slot_idx_i,
  output logic                         fill_done_o,
  output logic                         mem_we_o,
  output logic [SLOT_IDX_W+WORD_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0]            mem_wdata_o,
  output logic                         req_o,
  output logic [SLOT_IDX_W-1:0]        req_idx_o
);
  logic [WORD_W-1:0] word_q;
  logic              last_word;

  assign last_word   = (word_q == WORD_W'(SLOT_WORDS - 1));
  assign fill_done_o = beat_i && last_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q      <= '0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      req_o       <= 1'b0;
      req_idx_o   <= '0;
    end else begin
      mem_we_o <= beat_i;
      req_o    <= beat_i && last_word;
      if (beat_i) begin
        word_q      <= last_word ? '0 : word_q + {{(WORD_W-1){1'b0}}, 1'b1};
        mem_addr_o  <= {slot_idx_i, word_q};
        mem_wdata_o <= data_i;
        req_idx_o   <= slot_idx_i;
      end
    end
  end
endmodule

// File: rtl/stage_buf_ctrl.sv
`timescale 1ns/1ps
module stage_buf_ctrl #(
  parameter  int unsigned DATA_W     = stage_buf_pkg::DEF_DATA_W,
  parameter  int unsigned SLOT_BYTES = stage_buf_pkg::DEF_SLOT_BYTES,
  parameter  int unsigned NUM_SLOTS  = stage_buf_pkg::DEF_NUM_SLOTS,
  localparam int unsigned SLOT_WORDS = stage_buf_pkg::slot_words(DATA_W, SLOT_BYTES),
  localparam int unsigned WORD_W     = $clog2(SLOT_WORDS),
  localparam int unsigned SLOT_IDX_W = $clog2(NUM_SLOTS),
  localparam int unsigned ADDR_W     = SLOT_IDX_W + WORD_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_valid_i,
  input  logic [DATA_W-1:0]     in_data_i,
  output logic                  in_ready_o,
  output logic                  mem_we_o,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic [DATA_W-1:0]     mem_wdata_o,
  output logic                  slot_req_o,
  output logic [SLOT_IDX_W-1:0] slot_req_idx_o,
  input  logic                  dma_ack_i,
  output logic                  ack_err_o
);
  logic                  space, beat, fill_done;
  logic [SLOT_IDX_W-1:0] wr_idx;

  assign beat       = in_valid_i && space;
  assign in_ready_o = space;

  stage_ring_trk #(
    .NUM_SLOTS  (NUM_SLOTS),
    .SLOT_IDX_W (SLOT_IDX_W)
  ) ring_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fill_done_i (fill_done),
    .ack_i       (dma_ack_i),
    .space_o     (space),
    .wr_idx_o    (wr_idx),
    .err_o       (ack_err_o)
  );

  stage_fill_ctr #(
    .DATA_W     (DATA_W),
    .SLOT_WORDS (SLOT_WORDS),
    .SLOT_IDX_W (SLOT_IDX_W),
    .WORD_W     (WORD_W)
  ) fill_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .beat_i      (beat),
    .data_i      (in_data_i),
    .slot_idx_i  (wr_idx),
    .fill_done_o (fill_done),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .req_o       (slot_req_o),
    .req_idx_o   (slot_req_idx_o)
  );
endmodule

// File: rtl/stage_buf_chk.sv
`timescale 1ns/1ps
module stage_buf_chk #(
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned WORD_W     = 10,
  parameter int unsigned SLOT_IDX_W = 2
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         in_valid_i,
  input logic [DATA_W-1:0]            in_data_i,
  input logic                         in_ready_o,
  input logic                         mem_we_o,
  input logic [SLOT_IDX_W+WORD_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0]            mem_wdata_o,
  input logic                         slot_req_o,
  input logic [SLOT_IDX_W-1:0]        slot_req_idx_o,
  input logic                         ack_err_o
);
  logic [SLOT_IDX_W-1:0] exp_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         exp_idx_q <= '0;
    else if (slot_req_o) exp_idx_q <= exp_idx_q + {{(SLOT_IDX_W-1){1'b0}}, 1'b1};
  end

  a_r2_write_after_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (mem_we_o && mem_wdata_o == $past(in_data_i)));

  a_r8_no_write_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_ready_o) |=> !mem_we_o);

  a_r3_req_on_last_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_req_o |-> (mem_we_o && (&mem_addr_o[WORD_W-1:0])));

  a_r3_last_write_has_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && (&mem_addr_o[WORD_W-1:0])) |-> slot_req_o);

  a_r4_req_ring_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_req_o |-> (slot_req_idx_o == exp_idx_q &&
                    mem_addr_o[SLOT_IDX_W+WORD_W-1:WORD_W] == exp_idx_q));

  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_err_o |=> ack_err_o);
endmodule

bind stage_buf_ctrl stage_buf_chk #(
  .DATA_W     (DATA_W),
  .WORD_W     (WORD_W),
  .SLOT_IDX_W (SLOT_IDX_W)
) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .in_valid_i     (in_valid_i),
  .in_data_i      (in_data_i),
  .in_ready_o     (in_ready_o),
  .mem_we_o       (mem_we_o),
  .mem_addr_o     (mem_addr_o),
  .mem_wdata_o    (mem_wdata_o),
  .slot_req_o     (slot_req_o),
  .slot_req_idx_o (slot_req_idx_o),
  .ack_err_o      (ack_err_o)
);

// File: tb/stage_buf_ctrl_tb_top.sv
`timescale 1ns/1ps
module stage_buf_ctrl_tb_top;
  localparam int unsigned SLOT_WORDS = 1024;
  localparam int unsigned NUM_SLOTS  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        in_ready;
  logic        mem_we;
  logic [11:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        slot_req;
  logic [1:0]  slot_req_idx;
  logic        dma_ack = 1'b0;
  logic        ack_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  int exp_slot = 0;
  int exp_word = 0;

  always #2.5 clk = ~clk;

  stage_buf_ctrl dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .in_valid_i     (in_valid),
    .in_data_i      (in_data),
    .in_ready_o     (in_ready),
    .mem_we_o       (mem_we),
    .mem_addr_o     (mem_addr),
    .mem_wdata_o    (mem_wdata),
    .slot_req_o     (slot_req),
    .slot_req_idx_o (slot_req_idx),
    .dma_ack_i      (dma_ack),
    .ack_err_o      (ack_err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // starts and ends at a negedge; write is visible at the following negedge
  task automatic push_beat();
    logic [63:0] d;
    bit last;
    d = {32'hC0DE0000 | 32'(exp_slot), 32'(exp_word) ^ 32'h5A5A0000};
    last = (exp_word == SLOT_WORDS - 1);
    chk(in_ready == 1'b1, "R5 ready before beat", 64'(in_ready), 64'd1);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
    chk(mem_we == 1'b1, "R2 write enable", 64'(mem_we), 64'd1);
    chk(mem_addr == 12'(exp_slot * SLOT_WORDS + exp_word), "R2 address",
        64'(mem_addr), 64'(exp_slot * SLOT_WORDS + exp_word));
    chk(mem_wdata == d, "R2 write data", mem_wdata, d);
    chk(slot_req == last, "R3 request pulse", 64'(slot_req), 64'(last));
    if (last) begin
      chk(slot_req_idx == 2'(exp_slot), "R4 request index", 64'(slot_req_idx), 64'(exp_slot));
      exp_word = 0;
      exp_slot = (exp_slot + 1) % NUM_SLOTS;
    end else begin
      exp_word++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(mem_we == 1'b0, "R8 no write when idle", 64'(mem_we), 64'd0);
    end
  endtask

  task automatic ack_pulse();
    dma_ack = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0;
  endtask

  task automatic fill_slot();
    for (int w = 0; w < SLOT_WORDS; w++) push_beat();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready in reset", 64'(in_ready), 64'd1);
    chk(mem_we == 1'b0, "R1 no write in reset", 64'(mem_we), 64'd0);
    chk(slot_req == 1'b0, "R1 no request in reset", 64'(slot_req), 64'd0);
    chk(ack_err == 1'b0, "R1 error clear in reset", 64'(ack_err), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready after reset", 64'(in_ready), 64'd1);
    chk(mem_we == 1'b0, "R1 no write after reset", 64'(mem_we), 64'd0);
  endtask

  task automatic t_fill_with_gaps();
    for (int w = 0; w < SLOT_WORDS; w++) begin
      push_beat();
      if (w % 97 == 5) idle(2);   // R8: gaps keep position
    end
    chk(exp_slot == 1, "R4 advanced to slot 1", 64'(exp_slot), 64'd1);
  endtask

  task automatic t_fill_to_full();
    for (int s = 0; s < 3; s++) fill_slot();
    chk(in_ready == 1'b0, "R5 ready low when all slots wait", 64'(in_ready), 64'd0);
    in_valid = 1'b1;
    in_data  = 64'hDEAD_BEEF_0000_0001;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(mem_we == 1'b0, "R5 no write while full", 64'(mem_we), 64'd0);
      chk(in_ready == 1'b0, "R5 ready stays low", 64'(in_ready), 64'd0);
    end
    in_valid = 1'b0;
  endtask

  task automatic t_ack_release_wrap();
    ack_pulse();
    chk(in_ready == 1'b1, "R6 ready after one acknowledge", 64'(in_ready), 64'd1);
    chk(ack_err == 1'b0, "R6 valid acknowledge no error", 64'(ack_err), 64'd0);
    chk(exp_slot == 0, "R4 ring wraps to slot 0", 64'(exp_slot), 64'd0);
    fill_slot();
    chk(in_ready == 1'b0, "R6 one acknowledge frees one slot", 64'(in_ready), 64'd0);
  endtask

  task automatic t_spurious_ack();
    for (int i = 0; i < NUM_SLOTS; i++) ack_pulse();
    chk(ack_err == 1'b0, "R6 four valid acknowledges no error", 64'(ack_err), 64'd0);
    chk(in_ready == 1'b1, "R6 ready after releases", 64'(in_ready), 64'd1);
    ack_pulse();
    chk(ack_err == 1'b1, "R7 error on acknowledge with none waiting", 64'(ack_err), 64'd1);
    idle(3);
    chk(ack_err == 1'b1, "R7 error sticky", 64'(ack_err), 64'd1);
    chk(in_ready == 1'b1, "R7 ready unaffected", 64'(in_ready), 64'd1);
    chk(exp_slot == 1 && exp_word == 0, "R7 bench position", 64'(exp_slot), 64'd1);
    push_beat();   // R7: must land at slot 1 word 0
    push_beat();
    chk(ack_err == 1'b1, "R7 error still set", 64'(ack_err), 64'd1);
  endtask

  task automatic t_widths();
    chk($bits(mem_addr) == 12, "R9 address width", 64'($bits(mem_addr)), 64'd12);
    chk($bits(mem_wdata) == 64, "R9 data width", 64'($bits(mem_wdata)), 64'd64);
  endtask

  initial begin
    t_reset();
    t_widths();
    t_fill_with_gaps();
    t_fill_to_full();
    t_ack_release_wrap();
    t_spurious_ack();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule